// File: doc/BRIEF.md
# Sliding-Window Difference Rate Estimator

This block takes a stream of signed measurement samples. For each sample it accepts, it returns the difference between that sample and the one accepted a programmable number of samples earlier. The result approximates the rate of change of the measurement over a fixed time window; scaling by the time step is left to the consumer. The block keeps its history in a circular register store. A read pointer trails the write pointer by the captured window length, so the store holds exactly one window of samples.

The window length is a runtime input, but the block reads it only when a clear pulse arrives. A clear empties the history and captures the new length, saturated to the store depth. The first sample accepted after the clear is copied into every history slot. That fill sample yields no output. Every later sample yields one difference, one cycle after it is accepted. A captured length of zero leaves the history empty, and the block then stays silent until the next clear.

Top module: `rate_window_diff`

## Requirements
- R1: After reset the captured length is zero and `diff_valid` stays low, whatever samples arrive, until a clear with a nonzero length is followed by at least two samples.
- R2: On a clear the block captures `win_len` as the window length L, saturated to `MAX_LEN`. Changes to `win_len` while `clr` is low have no effect on any later difference.
- R3: The first sample accepted after a clear with L greater than 0 is written into every history slot. `diff_valid` is low in the cycle after that sample.
- R4: Every later accepted sample s produces, in the next cycle, `diff_valid` = 1 and `diff_data` = s minus the sample accepted L samples earlier. The fill sample stands in for every sample older than itself.
- R5: `diff_data` is a signed value of width DATA_W+1. It is exact for any pair of full-range signed inputs, including the largest minus the smallest and the reverse.
- R6: While the captured length is zero, no accepted sample produces an output, and the history stays empty until the next clear.
- R7: When `clr` and `smp_valid` are both high in the same cycle, the clear takes effect and the sample is discarded. The next accepted sample becomes the fill sample.
- R8: `diff_valid` is high only in the cycle after a sample was accepted while `clr` was low.
- R9: A cycle with `smp_valid` low changes neither the history nor the window position, and produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed measurement sample |
| win_len | input | LEN_IN_W | Requested window length, read only on a clear |
| clr | input | 1 | Clear pulse: flush the history and capture a new length |
| diff_valid | output | 1 | Difference strobe |
| diff_data | output | DATA_W+1 | Signed newest-minus-oldest difference |

## Verification
The bench runs a queue model through a series of clears. The lengths include zero, one, the full depth, and values above the depth. Sample gaps and stray changes to `win_len` are mixed into each run. Some cases catch common faults:
- If the read pointer were off by one, every difference would use the wrong partner.
- A broken saturation would shorten or alias the window whenever the request exceeds the depth.
- If the length were captured outside a clear, the window would move mid-stream.
- Without the extra output bit, the full-range swings between the extreme values would wrap to the wrong sign.
- A design that honoured the sample in a clear cycle would fill with a stale value.
- A design that did not gate the zero length would emit stale or undefined differences.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_RUN   = 2'd2
    } rwd_state_e;
endpackage

// File: rtl/rwd_ctrl.sv
module rwd_ctrl
    import rwd_pkg::*;
#(
    parameter int MAX_LEN  = 16,
    parameter int LEN_IN_W = 8,
    localparam int PTR_W   = $clog2(MAX_LEN),
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic                clr,
    input  logic [LEN_IN_W-1:0] win_len,
    output logic                fill_en,
    output logic                run_en,
    output logic [PTR_W-1:0]    wr_ptr,
    output logic [PTR_W-1:0]    rd_ptr,
    output logic [LEN_W-1:0]    len_o
);
    typedef struct packed {
        rwd_state_e       st;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] wp;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic [LEN_W-1:0] sat_len;
    logic [PTR_W:0]   rd_sum;

    always_comb begin
        if (win_len > LEN_IN_W'(MAX_LEN)) sat_len = LEN_W'(MAX_LEN);
        else                              sat_len = win_len[LEN_W-1:0];

        rd_sum = {1'b0, ctl_q.wp} + (PTR_W+1)'(MAX_LEN) - (PTR_W+1)'(ctl_q.len);
        if (rd_sum >= (PTR_W+1)'(MAX_LEN)) rd_sum = rd_sum - (PTR_W+1)'(MAX_LEN);

        ctl_d   = ctl_q;
        fill_en = 1'b0;
        run_en  = 1'b0;
        if (clr) begin
            ctl_d.len = sat_len;
            ctl_d.wp  = '0;
            ctl_d.st  = (sat_len == '0) ? ST_EMPTY : ST_FILL;
        end else if (smp_valid) begin
            unique case (ctl_q.st)
                ST_FILL: begin
                    fill_en  = 1'b1;
                    ctl_d.st = ST_RUN;
                end
                ST_RUN: begin
                    run_en   = 1'b1;
                    ctl_d.wp = (ctl_q.wp == PTR_W'(MAX_LEN - 1)) ? '0 : ctl_q.wp + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_EMPTY, len: '0, wp: '0};
        else        ctl_q <= ctl_d;
    end

    assign wr_ptr = ctl_q.wp;
    assign rd_ptr = rd_sum[PTR_W-1:0];
    assign len_o  = ctl_q.len;

    // R2
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> $stable(len_o));

    // R2
    len_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_o <= LEN_W'(MAX_LEN));
endmodule

// File: rtl/rwd_hist.sv
module rwd_hist #(
    parameter int DATA_W  = 12,
    parameter int MAX_LEN = 16,
    localparam int PTR_W  = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [PTR_W-1:0]  rd_ptr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_d [MAX_LEN];
    logic [DATA_W-1:0] mem_q [MAX_LEN];

    for (genvar i = 0; i < MAX_LEN; i++) begin : g_slot
        always_comb begin
            if (fill_en)                                  mem_d[i] = wr_data;
            else if (wr_en && (wr_ptr == PTR_W'(i)))      mem_d[i] = wr_data;
            else                                          mem_d[i] = mem_q[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_ptr];
endmodule

// File: rtl/rwd_sub.sv
module rwd_sub #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] new_s,
    input  logic [DATA_W-1:0] old_s,
    output logic              out_valid,
    output logic [DATA_W:0]   out_data
);
    typedef struct packed {
        logic            vld;
        logic [DATA_W:0] dif;
    } sub_t;

    sub_t sub_d, sub_q;

    always_comb begin
        sub_d     = sub_q;
        sub_d.vld = en;
        if (en) sub_d.dif = {new_s[DATA_W-1], new_s} - {old_s[DATA_W-1], old_s};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end

    assign out_valid = sub_q.vld;
    assign out_data  = sub_q.dif;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[DATA_W] == ($signed($past(new_s)) < $signed($past(old_s)))));
endmodule

// File: rtl/rate_window_diff.sv
module rate_window_diff #(
    parameter int DATA_W   = 12,
    parameter int MAX_LEN  = 16,
    parameter int LEN_IN_W = 8,
    localparam int PTR_W   = $clog2(MAX_LEN),
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [DATA_W-1:0]   smp_data,
    input  logic [LEN_IN_W-1:0] win_len,
    input  logic                clr,
    output logic                diff_valid,
    output logic [DATA_W:0]     diff_data
);
    logic              fill_en, run_en;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LEN_W-1:0]  cur_len;
    logic [DATA_W-1:0] oldest;

    rwd_ctrl #(.MAX_LEN(MAX_LEN), .LEN_IN_W(LEN_IN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .clr(clr),
        .win_len(win_len), .fill_en(fill_en), .run_en(run_en),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .len_o(cur_len)
    );

    rwd_hist #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_hist (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .wr_en(run_en),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_data(smp_data), .rd_data(oldest)
    );

    rwd_sub #(.DATA_W(DATA_W)) u_sub (
        .clk(clk), .rst_n(rst_n), .en(run_en), .new_s(smp_data),
        .old_s(oldest), .out_valid(diff_valid), .out_data(diff_data)
    );

    // R8
    no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && !clr) |=> !diff_valid);

    // R6
    zero_len_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_len == '0) |=> !diff_valid);

    // R3
    fill_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> !diff_valid);
endmodule

// File: tb/test_rate_window_diff.sv
`timescale 1ns/1ps
module test_rate_window_diff;
    localparam int DW = 12;
    localparam int ML = 16;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [LW-1:0] win_len = '0;
    logic          clr = 1'b0;
    logic          diff_valid;
    logic [DW:0]   diff_data;

    always #2.5 clk = ~clk;

    rate_window_diff #(.DATA_W(DW), .MAX_LEN(ML), .LEN_IN_W(LW)) i_rate_window_diff (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .win_len(win_len), .clr(clr), .diff_valid(diff_valid), .diff_data(diff_data)
    );

    int checks = 0;
    int errors = 0;
    int ref_len = 0;
    int ref_st = 0;          // 0 empty, 1 fill, 2 run
    int q[$];
    bit done = 0;
    bit pre_clear = 1;
    bit extreme = 0;

    function automatic int pat(int k, int seed);
        return ((k * 37 + seed * 101 + 11) % 4096) - 2048;
    endfunction

    task automatic step(bit v, int d, bit c, int l);
        bit    exp_v = 0;
        int    exp_d = 0;
        string tag;
        @(negedge clk);
        smp_valid = v; smp_data = DW'(d); clr = c; win_len = LW'(l);
        if (c) begin
            tag = v ? "R7" : "R2";
            ref_len = (l > ML) ? ML : l;
            ref_st = (ref_len == 0) ? 0 : 1;
            q.delete();
            pre_clear = 0;
        end else if (!v) begin
            tag = "R9";
        end else if (ref_st == 0) begin
            tag = pre_clear ? "R1" : "R6";
        end else if (ref_st == 1) begin
            tag = "R3";
            for (int i = 0; i < ref_len; i++) q.push_back(d);
            ref_st = 2;
        end else begin
            tag = extreme ? "R5" : "R4";
            exp_v = 1;
            exp_d = d - q[0];
            void'(q.pop_front());
            q.push_back(d);
        end
        @(posedge clk); #1;
        checks++;
        if (diff_valid !== exp_v) begin
            errors++;
            $display("FAIL %s: diff_valid=%0b expected %0b", tag, diff_valid, exp_v);
        end
        if (exp_v) begin
            checks++;
            if ($signed(diff_data) !== exp_d) begin
                errors++;
                $display("FAIL %s: diff_data=%0d expected %0d", tag, $signed(diff_data), exp_d);
            end
        end
    endtask

    initial begin
        int lens[9] = '{3, 1, 0, 2, 5, 16, 20, 255, 7};
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (diff_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: diff_valid=%0b expected 0 in reset", diff_valid);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1: samples before any clear produce nothing
        for (int k = 0; k < 5; k++) step(1, pat(k, 0), 0, 4);
        foreach (lens[j]) begin
            // odd runs: clear together with a sample (R7)
            step(j % 2, pat(j, 7), 1, lens[j]);
            for (int k = 0; k < 45; k++)
                step((k % 5) != 3, pat(k, j + 1), 0, (k * 13 + j) % 256); // R2 stray lengths
        end
        // R5: full-range swings at L=1 and L=16
        extreme = 1;
        step(0, 0, 1, 1);
        for (int k = 0; k < 10; k++) step(1, (k % 2) ? 2047 : -2048, 0, 9);
        step(0, 0, 1, 16);
        for (int k = 0; k < 40; k++) step(1, ((k / 16) % 2) ? -2048 : 2047, 0, 2);
        extreme = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule